// File: doc/BRIEF.md
# VLAN Membership Filter with Byte Parity

This block decides whether a received frame belongs to one of the VLANs the station has joined. Software programs a 4096-bit membership table through a simple register-style host port. The table is held as 128 words of 32 membership bits. Each word is protected by four odd-parity bits, one for each byte.

On each lookup request the block takes the frame's VLAN ID and a flag that says whether the frame carried a tag. It selects the table word, checks the word's parity and returns a registered member / not-member verdict one cycle later. A frame with no tag is looked up under a programmable implicit VLAN ID, and only while that ID is marked valid.

Normally the hardware computes the stored parity bits from the written data. A debug mode instead stores the parity bits exactly as software supplies them, so that faults can be injected. A parity failure raises a sticky error flag and records the VLAN ID being looked up. Software clears the flag by writing 1 to its bit, and that write also clears the recorded ID.

Top module: `vlan_member_filter`

## Requirements
- R1: Host addresses 0x00 to 0x7F select table word n. Bit k of word n is membership of VLAN ID 32n+k, so a tagged lookup of VLAN ID v returns bit v[4:0] of word v[11:5].
- R2: While the parity-debug bit is 0, a table write stores hardware parity in bits [35:32], and the parity bits supplied on the write are ignored. Bit 32+j is set exactly when byte j of the membership field holds an even number of ones.
- R3: While the parity-debug bit is 1, a table write stores host_wdata[35:32] unchanged as the parity bits.
- R4: A read request returns its data on host_rdata one cycle later. A table word reads as {parity[3:0], members[31:0]}. The control register at 0x80 reads as implicit VLAN ID in [11:0], implicit-valid in [12] and parity-debug in [13]. The error register at 0x81 reads as the logged VLAN ID in [11:0] and the error flag in [12].
- R5: res_valid is high exactly in the cycle after each cycle in which lk_req is high, and it carries that request's result.
- R6: An untagged lookup while implicit-valid is 1 returns the membership of the implicit VLAN ID.
- R7: An untagged lookup while implicit-valid is 0 returns not-member. It performs no parity check and raises no error.
- R8: If the selected word fails its parity check, the result shows res_par_err = 1 and res_member = 0.
- R9: A parity failure sets the error flag, and the flag stays set until software writes the error register with bit 12 = 1. That write clears both the flag and the logged ID.
- R10: The first parity failure seen while the flag is clear logs its effective VLAN ID. Later failures do not change the log while the flag stays set.
- R11: After reset every table word reads as zero members with correct parity ({4'hF, 32'h0}), both registers read 0, and res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 8 | Host word address |
| host_wdata | input | 36 | Host write data |
| host_rdata | output | 36 | Host read data, one cycle after host_rd |
| lk_req | input | 1 | Lookup request |
| lk_tagged | input | 1 | Frame carried a VLAN tag |
| lk_vid | input | 12 | VLAN ID from the tag |
| res_valid | output | 1 | Lookup result valid |
| res_member | output | 1 | Station is a member of the frame's VLAN |
| res_par_err | output | 1 | Selected word failed its parity check |

## Verification
The bench builds the block with its default parameters: 12-bit VLAN IDs and 32-bit words, which gives 128 words with four parity bytes each. At this size the first word, the last word (VLAN 4095) and both ends of a word (bit 0 and bit 31) can all be reached directly. A single word can also be given deliberately wrong parity and the error flag and log driven through set, hold and clear. Because the depth is the real one, the word-index and bit-index split of the VLAN ID is exercised exactly as it will be in use.

// File: rtl/vmf_pkg.sv
package vmf_pkg;
  localparam int unsigned VID_W_DEF  = 12;
  localparam int unsigned WORD_W_DEF = 32;

  // Odd parity bit for one byte: set when the byte has an even count of ones.
  function automatic logic odd_bit(input logic [7:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/vmf_table.sv
module vmf_table #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 7,
  localparam int unsigned PAR_W = WORD_W / 8,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_mem,
  input  logic [PAR_W-1:0]  wr_par,
  input  logic              par_dbg,
  input  logic [IDX_W-1:0]  a_idx,
  output logic [WORD_W-1:0] a_mem,
  output logic [PAR_W-1:0]  a_par,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [WORD_W-1:0] b_mem,
  output logic [PAR_W-1:0]  b_par
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PAR_W-1:0]  par_q [DEPTH];
  logic [PAR_W-1:0]  gen_par;
  logic [PAR_W-1:0]  st_par;

  for (genvar j = 0; j < PAR_W; j++) begin : g_par
    assign gen_par[j] = vmf_pkg::odd_bit(wr_mem[8*j +: 8]);
  end

  assign st_par = par_dbg ? wr_par : gen_par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= '0;
        par_q[i] <= '1;
      end
    end else if (wr_en) begin
      mem_q[wr_idx] <= wr_mem;
      par_q[wr_idx] <= st_par;
    end
  end

  assign a_mem = mem_q[a_idx];
  assign a_par = par_q[a_idx];
  assign b_mem = mem_q[b_idx];
  assign b_par = par_q[b_idx];
endmodule

// File: rtl/vmf_lookup.sv
module vmf_lookup #(
  parameter int unsigned VID_W  = 12,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned PAR_W = WORD_W / 8,
  localparam int unsigned BIT_W = $clog2(WORD_W),
  localparam int unsigned IDX_W = VID_W - BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic              lk_tagged,
  input  logic [VID_W-1:0]  lk_vid,
  input  logic [VID_W-1:0]  imp_vid,
  input  logic              imp_ok,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [WORD_W-1:0] word_mem,
  input  logic [PAR_W-1:0]  word_par,
  output logic              par_fail_ev,
  output logic [VID_W-1:0]  fail_vid,
  output logic              res_valid,
  output logic              res_member,
  output logic              res_par_err
);
  logic [VID_W-1:0] eff_vid;
  logic             use_tbl;
  logic [PAR_W-1:0] chk_par;
  logic             bad;
  logic             hit;

  for (genvar j = 0; j < PAR_W; j++) begin : g_chk
    assign chk_par[j] = vmf_pkg::odd_bit(word_mem[8*j +: 8]);
  end

  assign eff_vid     = lk_tagged ? lk_vid : imp_vid;
  assign use_tbl     = lk_tagged | imp_ok;
  assign rd_idx      = eff_vid[VID_W-1:BIT_W];
  assign bad         = (chk_par != word_par);
  assign hit         = word_mem[eff_vid[BIT_W-1:0]];
  assign par_fail_ev = lk_req & use_tbl & bad;
  assign fail_vid    = eff_vid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_member  <= 1'b0;
      res_par_err <= 1'b0;
    end else begin
      res_valid   <= lk_req;
      res_member  <= lk_req & use_tbl & ~bad & hit;
      res_par_err <= par_fail_ev;
    end
  end
endmodule

// File: rtl/vmf_errlog.sv
module vmf_errlog #(
  parameter int unsigned VID_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_ev,
  input  logic [VID_W-1:0] set_vid,
  input  logic             clr_ev,
  output logic             err_flag,
  output logic [VID_W-1:0] err_log
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_log  <= '0;
    end else if (set_ev && (!err_flag || clr_ev)) begin
      err_flag <= 1'b1;
      err_log  <= set_vid;
    end else if (clr_ev) begin
      err_flag <= 1'b0;
      err_log  <= '0;
    end
  end
endmodule

// File: rtl/vlan_member_filter.sv
module vlan_member_filter #(
  parameter int unsigned VID_W  = vmf_pkg::VID_W_DEF,
  parameter int unsigned WORD_W = vmf_pkg::WORD_W_DEF,
  localparam int unsigned PAR_W   = WORD_W / 8,
  localparam int unsigned BIT_W   = $clog2(WORD_W),
  localparam int unsigned IDX_W   = VID_W - BIT_W,
  localparam int unsigned HADDR_W = IDX_W + 1,
  localparam int unsigned HDATA_W = WORD_W + PAR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [HDATA_W-1:0] host_wdata,
  output logic [HDATA_W-1:0] host_rdata,
  input  logic               lk_req,
  input  logic               lk_tagged,
  input  logic [VID_W-1:0]   lk_vid,
  output logic               res_valid,
  output logic               res_member,
  output logic               res_par_err
);
  localparam logic [HADDR_W-1:0] CTRL_ADDR = HADDR_W'(1) << IDX_W;
  localparam logic [HADDR_W-1:0] ERR_ADDR  = CTRL_ADDR + HADDR_W'(1);

  logic [VID_W-1:0]  imp_vid;
  logic              imp_ok;
  logic              par_dbg;
  logic              tbl_wr;
  logic              clr_ev;
  logic              par_fail_ev;
  logic [VID_W-1:0]  fail_vid;
  logic              err_flag;
  logic [VID_W-1:0]  err_log;
  logic [IDX_W-1:0]  lk_idx;
  logic [WORD_W-1:0] lk_mem, h_mem;
  logic [PAR_W-1:0]  lk_par, h_par;

  assign tbl_wr = host_wr & ~host_addr[HADDR_W-1];
  assign clr_ev = host_wr & (host_addr == ERR_ADDR) & host_wdata[VID_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imp_vid <= '0;
      imp_ok  <= 1'b0;
      par_dbg <= 1'b0;
    end else if (host_wr && host_addr == CTRL_ADDR) begin
      imp_vid <= host_wdata[VID_W-1:0];
      imp_ok  <= host_wdata[VID_W];
      par_dbg <= host_wdata[VID_W+1];
    end
  end

  vmf_table #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_tbl (
    .clk, .rst_n,
    .wr_en   (tbl_wr),
    .wr_idx  (host_addr[IDX_W-1:0]),
    .wr_mem  (host_wdata[WORD_W-1:0]),
    .wr_par  (host_wdata[HDATA_W-1:WORD_W]),
    .par_dbg (par_dbg),
    .a_idx   (lk_idx),
    .a_mem   (lk_mem),
    .a_par   (lk_par),
    .b_idx   (host_addr[IDX_W-1:0]),
    .b_mem   (h_mem),
    .b_par   (h_par)
  );

  vmf_lookup #(.VID_W(VID_W), .WORD_W(WORD_W)) u_lk (
    .clk, .rst_n,
    .lk_req, .lk_tagged, .lk_vid,
    .imp_vid, .imp_ok,
    .rd_idx      (lk_idx),
    .word_mem    (lk_mem),
    .word_par    (lk_par),
    .par_fail_ev (par_fail_ev),
    .fail_vid    (fail_vid),
    .res_valid, .res_member, .res_par_err
  );

  vmf_errlog #(.VID_W(VID_W)) u_err (
    .clk, .rst_n,
    .set_ev  (par_fail_ev),
    .set_vid (fail_vid),
    .clr_ev  (clr_ev),
    .err_flag(err_flag),
    .err_log (err_log)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      if (!host_addr[HADDR_W-1])
        host_rdata <= {h_par, h_mem};
      else if (host_addr == CTRL_ADDR)
        host_rdata <= {{(HDATA_W-VID_W-2){1'b0}}, par_dbg, imp_ok, imp_vid};
      else if (host_addr == ERR_ADDR)
        host_rdata <= {{(HDATA_W-VID_W-1){1'b0}}, err_flag, err_log};
      else
        host_rdata <= '0;
    end
  end
endmodule

// File: rtl/vmf_checker.sv
module vmf_checker #(
  parameter int unsigned VID_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_req,
  input logic             lk_tagged,
  input logic             imp_ok,
  input logic             res_valid,
  input logic             res_member,
  input logic             res_par_err,
  input logic             par_fail_ev,
  input logic             clr_ev,
  input logic             err_flag,
  input logic [VID_W-1:0] err_log
);
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> res_valid);  // R5
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !res_valid);  // R5
  AST_UNTAGGED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req && !lk_tagged && !imp_ok |=> !res_member && !res_par_err);  // R7
  AST_PERR_BLOCKS_MEMBER: assert property (@(posedge clk) disable iff (!rst_n)
    res_par_err |-> res_valid && !res_member);  // R8
  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    par_fail_ev |=> err_flag);  // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !clr_ev |=> err_flag);  // R9
  AST_CLEAR_EMPTIES_LOG: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev && !par_fail_ev |=> !err_flag && err_log == '0);  // R9
  AST_LOG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !clr_ev |=> $stable(err_log));  // R10
endmodule

bind vlan_member_filter vmf_checker #(.VID_W(VID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_tagged(lk_tagged),
  .imp_ok(imp_ok), .res_valid(res_valid), .res_member(res_member),
  .res_par_err(res_par_err), .par_fail_ev(par_fail_ev), .clr_ev(clr_ev),
  .err_flag(err_flag), .err_log(err_log)
);

// File: tb/sim_vlan_member_filter.sv
module sim_vlan_member_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [35:0] host_wdata = '0;
  logic [35:0] host_rdata;
  logic        lk_req = 1'b0, lk_tagged = 1'b0;
  logic [11:0] lk_vid = '0;
  logic        res_valid, res_member, res_par_err;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  vlan_member_filter u0 (.*);

  // {tagged, vid[11:0], expected member}
  localparam logic [13:0] VEC [10] = '{
    {1'b1, 12'd0,    1'b1}, {1'b1, 12'd1,    1'b0}, {1'b1, 12'd2,    1'b1},
    {1'b1, 12'd96,   1'b1}, {1'b1, 12'd127,  1'b1}, {1'b1, 12'd126,  1'b0},
    {1'b1, 12'd4095, 1'b1}, {1'b1, 12'd4094, 1'b0}, {1'b0, 12'd5,    1'b1},
    {1'b1, 12'd3000, 1'b0}};

  function automatic logic [3:0] exp_par(input logic [31:0] d);
    logic [3:0] p;
    for (int j = 0; j < 4; j++) p[j] = ($countones(d[8*j +: 8]) % 2) == 0;
    return p;
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [35:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [35:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    d = host_rdata;
    host_rd = 1'b0;
  endtask

  task automatic look(input logic t, input logic [11:0] v, output logic [2:0] r);
    @(negedge clk);
    lk_req = 1'b1; lk_tagged = t; lk_vid = v;
    @(negedge clk);
    r = {res_valid, res_member, res_par_err};
    lk_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [35:0] rd;
    logic [2:0]  r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 res_valid", {35'd0, res_valid}, 36'd0);
    hread(8'h0A, rd); check("R11 word", rd, {4'hF, 32'h0});
    hread(8'h80, rd); check("R11 ctrl", rd, 36'd0);
    hread(8'h81, rd); check("R11 err", rd, 36'd0);
    look(1'b1, 12'd330, r); check("R11 lookup", {33'd0, r}, {33'd0, 3'b100});

    // program: implicit VID 96 valid, hardware parity
    hwrite(8'h80, 36'h0_0000_1060);
    hwrite(8'h00, {4'h0, 32'h0000_0005});
    hwrite(8'h03, {4'h0, 32'h8000_0001});
    hwrite(8'h7F, {4'h0, 32'h8000_0000});
    hread(8'h80, rd); check("R4 ctrl", rd, 36'h0_0000_1060);

    // R1 R6 vector walk
    for (int i = 0; i < 10; i++) begin
      logic [13:0] v;
      v = VEC[i];
      look(v[13], v[12:1], r);
      check(v[13] ? "R1 R5 tagged" : "R6 untagged", {33'd0, r}, {33'd0, 1'b1, v[0], 1'b0});
    end

    // R2 hardware parity, supplied bits ignored
    hread(8'h00, rd); check("R2 word0", rd, {exp_par(32'h5), 32'h5});
    hread(8'h03, rd); check("R2 word3", rd, {exp_par(32'h8000_0001), 32'h8000_0001});
    hwrite(8'h06, {4'h0, 32'h0000_0100});
    hread(8'h06, rd); check("R2 ignore", rd, {exp_par(32'h100), 32'h100});

    // R7 untagged with implicit invalid (VID 96 is a member)
    hwrite(8'h80, 36'h0_0000_0060);
    look(1'b0, 12'd0, r); check("R7 untagged off", {33'd0, r}, {33'd0, 3'b100});

    // R3 debug parity: word 5 bit0 (VID 160) with wrong parity
    hwrite(8'h80, 36'h0_0000_2060);
    hwrite(8'h05, {4'hF, 32'h0000_0001});
    hread(8'h05, rd); check("R3 stored", rd, {4'hF, 32'h1});

    // R8 R9 R10 error path
    look(1'b1, 12'd160, r); check("R8 perr", {33'd0, r}, {33'd0, 3'b101});
    hread(8'h81, rd); check("R9 flag", rd, {23'd0, 1'b1, 12'd160});
    look(1'b1, 12'd161, r); check("R8 perr2", {33'd0, r}, {33'd0, 3'b101});
    hread(8'h81, rd); check("R10 hold", rd, {23'd0, 1'b1, 12'd160});
    hwrite(8'h81, 36'h0_0000_0000);
    hread(8'h81, rd); check("R9 no clear on 0", rd, {23'd0, 1'b1, 12'd160});
    hwrite(8'h81, 36'h0_0000_1000);
    hread(8'h81, rd); check("R9 cleared", rd, 36'd0);
    look(1'b1, 12'd170, r); check("R8 perr3", {33'd0, r}, {33'd0, 3'b101});
    hread(8'h81, rd); check("R10 recapture", rd, {23'd0, 1'b1, 12'd170});
    look(1'b1, 12'd2, r); check("R1 good word", {33'd0, r}, {33'd0, 3'b110});

    finish_run();
  end
endmodule